// File: doc/BRIEF.md
# Banked Autoselect and CFI Read-Mode Controller

This block sits behind the command port of a multi-bank flash device and decides what a bus read returns. Bus writes carry commands. A three-write unlock sequence moves one bank into identifier mode. A one-write query command moves one bank into query mode, which serves a small read-only parameter table. A read/reset command moves back one mode level for each write. The bank is taken from the three highest address bits, and every mode applies to one bank only. Reads to any other bank return normal array contents.

Query mode remembers the mode it was entered from. When the query command is issued from identifier mode, it must name the bank that identifier mode was entered on. Leaving query mode therefore takes one reset write to return to identifier mode and a second reset write to reach plain array reads. The array is a behavioural read-only pattern. Programming and erasing are handled elsewhere.

Read data is registered. A read strobe in cycle N gives its data on `rd_data` after the clock edge that ends cycle N, and `rd_data` keeps that value until the next strobe.

Top module: `flash_readmode_ctrl`

## Requirements
- R1: While `rst_n` is low, the block enters array mode, clears the unlock tracker to idle and sets `rd_data` to 00h.
- R2: In array mode, a read returns `rd_addr[7:0] ^ {bank,5'b0}` one clock after `rd_en`. While `rd_en` is low, `rd_data` does not change.
- R3: In array mode, writing 98h to an address whose low 11 bits are 055h enters query mode on the written bank. Reads to that bank then return table data indexed by `rd_addr[7:0]`: 10h gives 51h, 11h gives 52h, 12h gives 59h, 27h gives ADDR_W+1 (17h by default), and every other index gives 00h.
- R4: In query mode, reads to a bank other than the query bank return array data.
- R5: In query mode, a further 98h@055h write is ignored, and the query bank stays the same.
- R6: In identifier mode, 98h@055h enters query mode only when its bank equals the identifier bank. Otherwise the block stays in identifier mode.
- R7: A write of F0h to any address moves back one level. Query mode returns to the mode it was entered from. Identifier mode returns to array mode. Array mode stays in array mode.
- R8: Identifier mode is entered by three writes, checked on the low 11 address bits: AAh@555h, then 55h@2AAh, then 90h@555h. The identifier bank comes from the third write, and the entry is accepted only outside query mode. Any write that breaks the sequence returns the tracker to idle, except AAh@555h, which restarts it at step one.
- R9: In identifier mode, reads to the identifier bank decode `rd_addr[7:0]` as follows: 00h gives MFR_CODE (20h); 01h gives DEV_CODE (7Eh); with bits 6, 3 and 2 low and bits 1 and 0 high, the result is 80h when `ext_locked` is high and 00h when it is low; every other index gives 00h. Reads to other banks return array data.
- R10: When a read and a command write fall in the same cycle, the read is served in the mode that was in force before that write.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write word address, bank in top 3 bits |
| wr_data | input | 8 | Bus write data (command byte) |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read word address, bank in top 3 bits |
| ext_locked | input | 1 | Extended block is factory locked |
| rd_data | output | 8 | Registered read data |

## Verification
A read and a mode-changing command write can fall in the same cycle. The bench provokes this by asserting the F0h reset write and a read of the identifier bank on the same clock edge while the block is in identifier mode. It expects the manufacturer code from the old mode. A following read must then return array data, which shows that the write took effect.

// File: rtl/flash_readmode_ctrl.sv
`timescale 1ns/1ps
module flash_readmode_ctrl #(
  parameter int ADDR_W = 22,
  parameter int BANK_W = 3,
  parameter int CMD_AW = 11,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ext_locked,
  output logic [7:0]        rd_data
);
  localparam logic [CMD_AW-1:0] A_555 = CMD_AW'('h555);
  localparam logic [CMD_AW-1:0] A_2AA = CMD_AW'('h2AA);
  localparam logic [CMD_AW-1:0] A_055 = CMD_AW'('h055);
  localparam logic [7:0] SIZE_BYTE = 8'(ADDR_W + 1);

  typedef enum logic [1:0] {M_ARRAY, M_AUTO, M_CFI} mode_t;
  typedef enum logic [1:0] {UL_IDLE, UL_ONE, UL_TWO} ul_t;

  mode_t mode;
  ul_t ul;
  logic [BANK_W-1:0] auto_bank, cfi_bank;
  logic cfi_from_auto;

  wire [BANK_W-1:0] wr_bank = wr_addr[ADDR_W-1 -: BANK_W];
  wire [CMD_AW-1:0] wr_ca   = wr_addr[CMD_AW-1:0];
  wire is_reset = wr_en && wr_data == 8'hF0;
  wire is_cfi   = wr_en && wr_data == 8'h98 && wr_ca == A_055;
  wire ul_s1    = wr_data == 8'hAA && wr_ca == A_555;
  wire ul_s2    = wr_data == 8'h55 && wr_ca == A_2AA;
  wire ul_s3    = wr_data == 8'h90 && wr_ca == A_555;
  wire cfi_ok   = (mode == M_ARRAY) || (mode == M_AUTO && wr_bank == auto_bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_ARRAY;
      ul <= UL_IDLE;
      auto_bank <= '0;
      cfi_bank <= '0;
      cfi_from_auto <= 1'b0;
    end else if (is_reset) begin
      ul <= UL_IDLE;
      case (mode)
        M_CFI:   mode <= cfi_from_auto ? M_AUTO : M_ARRAY;
        M_AUTO:  mode <= M_ARRAY;
        default: mode <= M_ARRAY;
      endcase
    end else if (is_cfi) begin
      ul <= UL_IDLE;
      if (cfi_ok) begin
        mode <= M_CFI;
        cfi_bank <= wr_bank;
        cfi_from_auto <= (mode == M_AUTO);
      end
    end else if (wr_en) begin
      if (ul == UL_ONE && ul_s2) ul <= UL_TWO;
      else if (ul == UL_TWO && ul_s3) begin
        ul <= UL_IDLE;
        if (mode != M_CFI) begin
          mode <= M_AUTO;
          auto_bank <= wr_bank;
        end
      end
      else if (ul_s1) ul <= UL_ONE;
      else ul <= UL_IDLE;
    end
  end

  wire [BANK_W-1:0] rd_bank = rd_addr[ADDR_W-1 -: BANK_W];
  wire [7:0] rd_lo = rd_addr[7:0];
  wire [7:0] arr_word = rd_lo ^ 8'({rd_bank, 5'b00000});
  wire status_hit = !rd_lo[6] && !rd_lo[3] && !rd_lo[2] && rd_lo[1] && rd_lo[0];

  logic [7:0] cfi_byte, id_byte, rd_next;

  always_comb begin
    case (rd_lo)
      8'h10:   cfi_byte = 8'h51;
      8'h11:   cfi_byte = 8'h52;
      8'h12:   cfi_byte = 8'h59;
      8'h27:   cfi_byte = SIZE_BYTE;
      default: cfi_byte = 8'h00;
    endcase
  end

  always_comb begin
    if (rd_lo == 8'h00)  id_byte = MFR_CODE;
    else if (rd_lo == 8'h01) id_byte = DEV_CODE;
    else if (status_hit) id_byte = ext_locked ? 8'h80 : 8'h00;
    else id_byte = 8'h00;
  end

  always_comb begin
    case (mode)
      M_AUTO:  rd_next = (rd_bank == auto_bank) ? id_byte : arr_word;
      M_CFI:   rd_next = (rd_bank == cfi_bank) ? cfi_byte : arr_word;
      default: rd_next = arr_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_next;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R2
  AST_CFI_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && mode == M_CFI && rd_bank != cfi_bank |=> rd_data == ($past(rd_addr[7:0]) ^ 8'({$past(rd_bank), 5'b00000}))); // R4
  AST_CFI_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_CFI && is_cfi |=> mode == M_CFI && $stable(cfi_bank)); // R5
  AST_CFI_BANK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_AUTO && is_cfi && wr_bank != auto_bank |=> mode == M_AUTO); // R6
  AST_UNWIND_TO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_CFI && cfi_from_auto && is_reset |=> mode == M_AUTO); // R7
  AST_AUTO_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_AUTO && is_reset |=> mode == M_ARRAY); // R7
  AST_UNLOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ul == UL_TWO && !is_reset && !is_cfi && !ul_s3 && !ul_s1 |=> ul == UL_IDLE); // R8
  AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && mode == M_AUTO && rd_bank == auto_bank && status_hit |=> rd_data == ($past(ext_locked) ? 8'h80 : 8'h00)); // R9
endmodule

// File: tb/flash_readmode_ctrl_bench.sv
`timescale 1ns/1ps
module flash_readmode_ctrl_bench;
  localparam int AW = 22;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ext_locked = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_readmode_ctrl u_flash_readmode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .ext_locked(ext_locked), .rd_data(rd_data));

  localparam logic [1:0] OW = 2'd0, RA = 2'd1, RD = 2'd2;
  localparam int NV = 40;
  // fields: requirement, op, bank, offset, data (write data or expected byte)
  localparam logic [35:0] VEC [NV] = '{
    {4'd2, RA, 3'd3, 19'h010, 8'h00},  // R2 array after reset
    {4'd3, OW, 3'd3, 19'h055, 8'h98},  // R3 enter query, bank 3
    {4'd3, RD, 3'd3, 19'h010, 8'h51},
    {4'd3, RD, 3'd3, 19'h012, 8'h59},
    {4'd3, RD, 3'd3, 19'h027, 8'h17},
    {4'd3, RD, 3'd3, 19'h030, 8'h00},
    {4'd4, RA, 3'd5, 19'h010, 8'h00},  // R4 other bank
    {4'd5, OW, 3'd5, 19'h055, 8'h98},  // R5 ignored
    {4'd5, RA, 3'd5, 19'h010, 8'h00},
    {4'd5, RD, 3'd3, 19'h011, 8'h52},
    {4'd7, OW, 3'd0, 19'h000, 8'hF0},  // R7 back to array
    {4'd7, RA, 3'd3, 19'h010, 8'h00},
    {4'd8, OW, 3'd0, 19'h555, 8'hAA},  // R8 unlock
    {4'd8, OW, 3'd0, 19'h2AA, 8'h55},
    {4'd8, OW, 3'd5, 19'h555, 8'h90},
    {4'd9, RD, 3'd5, 19'h000, 8'h20},  // R9 ids
    {4'd9, RD, 3'd5, 19'h001, 8'h7E},
    {4'd9, RD, 3'd5, 19'h003, 8'h00},
    {4'd9, RD, 3'd5, 19'h005, 8'h00},
    {4'd9, RA, 3'd2, 19'h010, 8'h00},
    {4'd6, OW, 3'd2, 19'h055, 8'h98},  // R6 wrong bank
    {4'd6, RA, 3'd2, 19'h010, 8'h00},
    {4'd6, RD, 3'd5, 19'h000, 8'h20},
    {4'd6, OW, 3'd5, 19'h055, 8'h98},  // R6 same bank
    {4'd6, RD, 3'd5, 19'h010, 8'h51},
    {4'd7, OW, 3'd1, 19'h123, 8'hF0},  // R7 query -> identifier
    {4'd7, RD, 3'd5, 19'h001, 8'h7E},
    {4'd7, OW, 3'd1, 19'h000, 8'hF0},  // R7 identifier -> array
    {4'd7, RA, 3'd5, 19'h001, 8'h00},
    {4'd8, OW, 3'd0, 19'h555, 8'hAA},  // R8 bad third write
    {4'd8, OW, 3'd0, 19'h2AA, 8'h55},
    {4'd8, OW, 3'd0, 19'h555, 8'h12},
    {4'd8, OW, 3'd0, 19'h555, 8'h90},
    {4'd8, RA, 3'd0, 19'h000, 8'h00},
    {4'd8, OW, 3'd0, 19'h555, 8'hAA},  // R8 bad second address
    {4'd8, OW, 3'd0, 19'h2AB, 8'h55},
    {4'd8, OW, 3'd0, 19'h555, 8'h90},
    {4'd8, RA, 3'd0, 19'h001, 8'h00},
    {4'd7, OW, 3'd0, 19'h000, 8'hF0},  // R7 array stays array
    {4'd7, RA, 3'd4, 19'h020, 8'h00}
  };

  function automatic logic [7:0] arr_exp(input logic [2:0] b, input logic [18:0] off);
    return off[7:0] ^ {b, 5'b00000};
  endfunction

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] b, input logic [18:0] off, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = {b, off}; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] b, input logic [18:0] off);
    @(negedge clk); rd_en = 1'b1; rd_addr = {b, off};
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, rd_data, 8'h00);  // R1 reset value

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      if (v[31:30] == OW) wr(v[29:27], v[26:8], v[7:0]);
      else begin
        rd(v[29:27], v[26:8]);
        chk(int'(v[35:32]), rd_data, v[31:30] == RA ? arr_exp(v[29:27], v[26:8]) : v[7:0]);
      end
    end

    // R9 status byte with lock set and don't-care bits
    ext_locked = 1'b1;
    wr(3'd0, 19'h555, 8'hAA); wr(3'd0, 19'h2AA, 8'h55); wr(3'd7, 19'h555, 8'h90);
    rd(3'd7, 19'h1B3); chk(9, rd_data, 8'h80);
    rd(3'd7, 19'h003); chk(9, rd_data, 8'h80);
    rd(3'd7, 19'h04B); chk(9, rd_data, 8'h00);

    // R10 read and reset write in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = '0; wr_data = 8'hF0;
    rd_en = 1'b1; rd_addr = {3'd7, 19'h000};
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk(10, rd_data, 8'h20);
    rd(3'd7, 19'h000); chk(7, rd_data, arr_exp(3'd7, 19'h000));  // R7

    // R8 repeated AAh restarts the tracker
    wr(3'd0, 19'h555, 8'hAA); wr(3'd0, 19'h555, 8'hAA);
    wr(3'd0, 19'h2AA, 8'h55); wr(3'd1, 19'h555, 8'h90);
    rd(3'd1, 19'h000); chk(8, rd_data, 8'h20);

    // R1 reset in query mode
    wr(3'd0, 19'h000, 8'hF0);
    wr(3'd1, 19'h055, 8'h98);
    rd(3'd1, 19'h010); chk(3, rd_data, 8'h51);
    wr(3'd0, 19'h555, 8'hAA);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(1, rd_data, 8'h00);
    rst_n = 1'b1;
    rd(3'd1, 19'h010); chk(1, rd_data, arr_exp(3'd1, 19'h010));
    wr(3'd0, 19'h2AA, 8'h55); wr(3'd0, 19'h555, 8'h90);
    rd(3'd0, 19'h000); chk(1, rd_data, arr_exp(3'd0, 19'h000));

    finish_run();
  end
endmodule